// File: doc/BRIEF.md
# Batching DRAM Request Scheduler

This block holds a small queue of pending DRAM requests and decides, one per cycle, which one is granted to the memory. Each request names the processor that issued it and the bank, row and column it targets. To stop one processor with good row locality from starving the others, the scheduler groups requests into batches. A batch is formed from the requests that are waiting at the moment the previous batch runs dry. For every pairing of processor and bank, only the oldest few requests are let into a batch. Requests that were not let in, and requests that arrive while a batch is being served, wait for a later batch.

Inside a batch the scheduler looks only at requests whose bank is not flagged busy, so work spreads across banks that can accept it. Among those, a request that hits the row last opened in its bank comes first. After that, the request that arrived first wins. The queue is kept compacted in arrival order, so slot 0 always holds the oldest request. A per-bank busy flag from outside is the only DRAM timing the block sees.

Top module: `batch_sched`

## Requirements
- R1: After reset no grant is presented (`grantValid` low) and the queue accepts requests (`enqReady` high).
- R2: A request is granted only if it belongs to the current batch. While any batch member is still pending, no request outside the batch is granted, even when its bank is free.
- R3: A new batch takes in at most CAP requests (default 2) per processor/bank pair, and for each pair it takes the oldest ones. Requests left out are served in a later batch.
- R4: A batch member whose bank busy flag is set is not granted. A younger batch member whose bank is free may be granted ahead of it.
- R5: Among batch members whose banks are free, a request whose row equals the row last granted in its bank is chosen before any request that misses.
- R6: When R4 and R5 leave more than one candidate, the request that arrived earliest is granted.
- R7: The queue holds DEPTH requests (default 8). When it is full, `enqReady` is low and a request offered on the enqueue port is dropped and never granted.
- R8: At most one grant is issued per cycle. `grantValid` stays high for one cycle per request, and the grant carries the processor, bank, row and column that were enqueued with that request.
- R9: The cycle in which a batch is formed issues no grant. A request enqueued into an idle scheduler at clock edge k is granted at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Offer a request this cycle |
| enqReady | output | 1 | Queue has a free slot |
| enqSrc | input | SRC_W | Issuing processor |
| enqBank | input | BANK_W | Target bank |
| enqRow | input | ROW_W | Target row |
| enqCol | input | COL_W | Target column |
| bankBusy | input | NUM_BANKS | Per-bank busy flag; a set bit blocks grants to that bank |
| grantValid | output | 1 | Grant presented this cycle |
| grantSrc | output | SRC_W | Processor of the granted request |
| grantBank | output | BANK_W | Bank of the granted request |
| grantRow | output | ROW_W | Row of the granted request |
| grantCol | output | COL_W | Column of the granted request |

## Verification
Each ordering scenario starts by parking a single-request batch behind a busy bank, so that the requests under test queue up unmarked and then enter one batch together. Three same-source/same-bank requests plus one from a second source give the order 1,2,4,3 only if the per-pair cap is enforced; a plain oldest-first scheduler would give 1,2,3,4. Separate patterns tell the ordering rules apart: a busy older request against a free younger one, a row miss against a younger row hit, and two free misses. A filled queue with one extra offer checks the drop, and a lone request into an idle scheduler checks the two-edge latency.

// File: rtl/batch_sched_pkg.sv
package batch_sched_pkg;
  typedef struct packed {
    logic formBatch;
    logic grantFire;
  } sched_strobe_t;
endpackage

// File: rtl/batch_sched_queue.sv
module batch_sched_queue
  import batch_sched_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NUM_BANKS = 4,
  parameter int SRC_W     = 2,
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int CAP       = 2,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enqValid,
  output logic                 enqReady,
  input  logic [SRC_W-1:0]     enqSrc,
  input  logic [BANK_W-1:0]    enqBank,
  input  logic [ROW_W-1:0]     enqRow,
  input  logic [COL_W-1:0]     enqCol,
  input  logic [NUM_BANKS-1:0] bankBusy,
  input  sched_strobe_t        ctl,
  input  logic [IDX_W-1:0]     selIdx,
  output logic [DEPTH-1:0]     validVec,
  output logic [DEPTH-1:0]     markVec,
  output logic [DEPTH-1:0]     readyVec,
  output logic [DEPTH-1:0]     hitVec,
  output logic                 grantValid,
  output logic [SRC_W-1:0]     grantSrc,
  output logic [BANK_W-1:0]    grantBank,
  output logic [ROW_W-1:0]     grantRow,
  output logic [COL_W-1:0]     grantCol
);
  logic [SRC_W-1:0]  srcQ  [DEPTH];
  logic [BANK_W-1:0] bankQ [DEPTH];
  logic [ROW_W-1:0]  rowQ  [DEPTH];
  logic [COL_W-1:0]  colQ  [DEPTH];
  logic [DEPTH-1:0]  markQ;
  logic [CNT_W-1:0]  countQ;

  logic [ROW_W-1:0]     openRow [NUM_BANKS];
  logic [NUM_BANKS-1:0] openVld;

  logic [SRC_W-1:0]  srcN  [DEPTH];
  logic [BANK_W-1:0] bankN [DEPTH];
  logic [ROW_W-1:0]  rowN  [DEPTH];
  logic [COL_W-1:0]  colN  [DEPTH];
  logic [DEPTH-1:0]  markN, newMark, markBase;
  logic [CNT_W-1:0]  cntAfter, countN;
  logic              enqAccept;

  assign enqReady  = (countQ < CNT_W'(DEPTH));
  assign enqAccept = enqValid && enqReady;
  assign markVec   = markQ & validVec;

  // Status vectors toward the control
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      validVec[i] = (CNT_W'(i) < countQ);
      readyVec[i] = validVec[i] && !bankBusy[bankQ[i]];
      hitVec[i]   = validVec[i] && openVld[bankQ[i]] && (openRow[bankQ[i]] == rowQ[i]);
    end
  end

  // Batch marking: the oldest CAP requests of each source/bank pair
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int sameOlder;
      sameOlder = 0;
      for (int j = 0; j < i; j++) begin
        if (validVec[j] && srcQ[j] == srcQ[i] && bankQ[j] == bankQ[i])
          sameOlder = sameOlder + 1;
      end
      newMark[i] = validVec[i] && (sameOlder < CAP);
    end
  end

  assign markBase = ctl.formBatch ? newMark : markQ;

  // Compaction on grant, then append
  always_comb begin
    cntAfter = countQ - (ctl.grantFire ? CNT_W'(1) : CNT_W'(0));
    countN   = cntAfter + (enqAccept ? CNT_W'(1) : CNT_W'(0));
    for (int i = 0; i < DEPTH; i++) begin
      if (ctl.grantFire && i >= int'(selIdx)) begin
        srcN[i]  = srcQ[(i + 1) % DEPTH];
        bankN[i] = bankQ[(i + 1) % DEPTH];
        rowN[i]  = rowQ[(i + 1) % DEPTH];
        colN[i]  = colQ[(i + 1) % DEPTH];
        markN[i] = (i < DEPTH - 1) ? markBase[(i + 1) % DEPTH] : 1'b0;
      end else begin
        srcN[i]  = srcQ[i];
        bankN[i] = bankQ[i];
        rowN[i]  = rowQ[i];
        colN[i]  = colQ[i];
        markN[i] = markBase[i];
      end
      if (enqAccept && CNT_W'(i) == cntAfter) begin
        srcN[i]  = enqSrc;
        bankN[i] = enqBank;
        rowN[i]  = enqRow;
        colN[i]  = enqCol;
        markN[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ     <= '0;
      markQ      <= '0;
      openVld    <= '0;
      grantValid <= 1'b0;
      grantSrc   <= '0;
      grantBank  <= '0;
      grantRow   <= '0;
      grantCol   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        srcQ[i]  <= '0;
        bankQ[i] <= '0;
        rowQ[i]  <= '0;
        colQ[i]  <= '0;
      end
      for (int b = 0; b < NUM_BANKS; b++) openRow[b] <= '0;
    end else begin
      countQ     <= countN;
      markQ      <= markN;
      grantValid <= ctl.grantFire;
      for (int i = 0; i < DEPTH; i++) begin
        srcQ[i]  <= srcN[i];
        bankQ[i] <= bankN[i];
        rowQ[i]  <= rowN[i];
        colQ[i]  <= colN[i];
      end
      if (ctl.grantFire) begin
        grantSrc               <= srcQ[selIdx];
        grantBank              <= bankQ[selIdx];
        grantRow               <= rowQ[selIdx];
        grantCol               <= colQ[selIdx];
        openRow[bankQ[selIdx]] <= rowQ[selIdx];
        openVld[bankQ[selIdx]] <= 1'b1;
      end
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(DEPTH));
  assert_form_when_drained_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.formBatch |-> (markQ == '0));
  assert_grant_in_batch_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.grantFire |-> markQ[selIdx]);
  assert_grant_bank_free_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.grantFire |-> !bankBusy[bankQ[selIdx]]);
  assert_form_no_grant_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.formBatch |=> !grantValid);
endmodule

// File: rtl/batch_sched_ctrl.sv
module batch_sched_ctrl
  import batch_sched_pkg::*;
#(
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DEPTH-1:0] validVec,
  input  logic [DEPTH-1:0] markVec,
  input  logic [DEPTH-1:0] readyVec,
  input  logic [DEPTH-1:0] hitVec,
  output sched_strobe_t    ctl,
  output logic [IDX_W-1:0] selIdx
);
  logic [DEPTH-1:0] candAll, candHit, pick;

  assign candAll = markVec & readyVec;
  assign candHit = candAll & hitVec;
  assign pick    = (|candHit) ? candHit : candAll;

  always_comb begin
    selIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (pick[i]) selIdx = IDX_W'(i);
    end
  end

  assign ctl.formBatch = (markVec == '0) && (|validVec);
  assign ctl.grantFire = |pick;

  assert_hit_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.grantFire && |(markVec & readyVec & hitVec)) |-> hitVec[selIdx]);
  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.formBatch && ctl.grantFire));
endmodule

// File: rtl/batch_sched.sv
module batch_sched
  import batch_sched_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NUM_SRC   = 4,
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int CAP       = 2,
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enqValid,
  output logic                 enqReady,
  input  logic [SRC_W-1:0]     enqSrc,
  input  logic [BANK_W-1:0]    enqBank,
  input  logic [ROW_W-1:0]     enqRow,
  input  logic [COL_W-1:0]     enqCol,
  input  logic [NUM_BANKS-1:0] bankBusy,
  output logic                 grantValid,
  output logic [SRC_W-1:0]     grantSrc,
  output logic [BANK_W-1:0]    grantBank,
  output logic [ROW_W-1:0]     grantRow,
  output logic [COL_W-1:0]     grantCol
);
  sched_strobe_t    ctl;
  logic [IDX_W-1:0] selIdx;
  logic [DEPTH-1:0] validVec, markVec, readyVec, hitVec;

  batch_sched_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .validVec(validVec), .markVec(markVec),
    .readyVec(readyVec), .hitVec(hitVec), .ctl(ctl), .selIdx(selIdx)
  );

  batch_sched_queue #(
    .DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .SRC_W(SRC_W), .BANK_W(BANK_W),
    .ROW_W(ROW_W), .COL_W(COL_W), .CAP(CAP)
  ) u_queue (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqReady(enqReady),
    .enqSrc(enqSrc), .enqBank(enqBank), .enqRow(enqRow), .enqCol(enqCol),
    .bankBusy(bankBusy), .ctl(ctl), .selIdx(selIdx),
    .validVec(validVec), .markVec(markVec), .readyVec(readyVec), .hitVec(hitVec),
    .grantValid(grantValid), .grantSrc(grantSrc), .grantBank(grantBank),
    .grantRow(grantRow), .grantCol(grantCol)
  );
endmodule

// File: tb/batch_sched_bench.sv
module batch_sched_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enqValid = 1'b0;
  logic       enqReady;
  logic [1:0] enqSrc = '0;
  logic [1:0] enqBank = '0;
  logic [7:0] enqRow = '0;
  logic [5:0] enqCol = '0;
  logic [3:0] bankBusy = '0;
  logic       grantValid;
  logic [1:0] grantSrc, grantBank;
  logic [7:0] grantRow;
  logic [5:0] grantCol;

  int checks = 0;
  int fails = 0;
  int logN = 0;
  logic [1:0] logSrc [64];
  logic [1:0] logBank [64];
  logic [7:0] logRow [64];
  logic [5:0] logCol [64];

  always #2 clk = ~clk;

  batch_sched u_batch_sched (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqReady(enqReady),
    .enqSrc(enqSrc), .enqBank(enqBank), .enqRow(enqRow), .enqCol(enqCol),
    .bankBusy(bankBusy), .grantValid(grantValid), .grantSrc(grantSrc),
    .grantBank(grantBank), .grantRow(grantRow), .grantCol(grantCol)
  );

  always @(negedge clk) begin
    if (rstN && grantValid && logN < 64) begin
      logSrc[logN]  <= grantSrc;
      logBank[logN] <= grantBank;
      logRow[logN]  <= grantRow;
      logCol[logN]  <= grantCol;
      logN <= logN + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enq(input int s, input int b, input int r, input int c);
    enqValid = 1'b1;
    enqSrc = 2'(s); enqBank = 2'(b); enqRow = 8'(r); enqCol = 6'(c);
    @(negedge clk);
    enqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Park a one-request batch on busy bank 3 so later requests queue unmarked
  task automatic park(input int c);
    bankBusy[3] = 1'b1;
    enq(3, 3, 0, c);
    idle(1);
  endtask

  task automatic expectGrant(input int k, input int s, input int b, input int r,
                             input int c, input string req);
    logic [5:0] gotCol;
    gotCol = (k < logN) ? logCol[k] : 6'h3f;
    check(k < logN && logCol[k] == 6'(c), req, int'(gotCol), c);
    if (k < logN) begin
      check(logSrc[k] == 2'(s) && logBank[k] == 2'(b) && logRow[k] == 8'(r),
            "R8 fields", int'({logSrc[k], logBank[k], logRow[k]}),
            int'({2'(s), 2'(b), 8'(r)}));
    end
  endtask

  task automatic testReset();
    check(grantValid == 1'b0, "R1 grantValid", int'(grantValid), 0);
    check(enqReady == 1'b1, "R1 enqReady", int'(enqReady), 1);
  endtask

  task automatic testLatency();
    int base;
    base = logN;
    enq(2, 1, 7, 50);
    check(grantValid == 1'b0, "R9 edge k", int'(grantValid), 0);
    idle(1);
    check(grantValid == 1'b0, "R9 form edge", int'(grantValid), 0);
    idle(1);
    check(grantValid == 1'b1 && grantCol == 6'd50, "R9 edge k+2", int'(grantCol), 50);
    idle(1);
    check(grantValid == 1'b0, "R8 single pulse", int'(grantValid), 0);
    check(logN - base == 1, "R8 grant count", logN - base, 1);
  endtask

  task automatic testCap();
    int base;
    base = logN;
    park(1);
    enq(0, 0, 1, 2);
    enq(0, 0, 2, 3);
    enq(0, 0, 3, 4);
    enq(1, 0, 4, 5);
    idle(5);
    check(logN == base, "R2 no grant outside batch", logN - base, 0);
    bankBusy[3] = 1'b0;
    idle(12);
    expectGrant(base + 0, 3, 3, 0, 1, "R2 parked first");
    expectGrant(base + 1, 0, 0, 1, 2, "R3 cap order 1");
    expectGrant(base + 2, 0, 0, 2, 3, "R3 cap order 2");
    expectGrant(base + 3, 1, 0, 4, 5, "R3 other source in batch");
    expectGrant(base + 4, 0, 0, 3, 4, "R3 capped request next batch");
  endtask

  task automatic testBusy();
    int base;
    base = logN;
    bankBusy[1] = 1'b1;
    park(10);
    enq(0, 1, 20, 11);
    enq(0, 2, 5, 12);
    bankBusy[3] = 1'b0;
    idle(6);
    expectGrant(base + 0, 3, 3, 0, 10, "R4 parked");
    expectGrant(base + 1, 0, 2, 5, 12, "R4 free bank first");
    check(logN - base == 2, "R4 busy bank held", logN - base, 2);
    bankBusy[1] = 1'b0;
    idle(4);
    expectGrant(base + 2, 0, 1, 20, 11, "R4 after release");
  endtask

  task automatic testHit();
    int base;
    base = logN;
    park(20);
    enq(1, 2, 6, 21);
    enq(2, 2, 5, 22);
    bankBusy[3] = 1'b0;
    idle(8);
    expectGrant(base + 0, 3, 3, 0, 20, "R5 parked");
    expectGrant(base + 1, 2, 2, 5, 22, "R5 row hit first");
    expectGrant(base + 2, 1, 2, 6, 21, "R5 miss after hit");
  endtask

  task automatic testOldest();
    int base;
    base = logN;
    park(30);
    enq(0, 0, 9, 31);
    enq(1, 1, 9, 32);
    bankBusy[3] = 1'b0;
    idle(8);
    expectGrant(base + 0, 3, 3, 0, 30, "R6 parked");
    expectGrant(base + 1, 0, 0, 9, 31, "R6 oldest first");
    expectGrant(base + 2, 1, 1, 9, 32, "R6 younger second");
  endtask

  task automatic testFull();
    int base;
    bit seen;
    base = logN;
    park(40);
    for (int i = 0; i < 7; i++) enq(i % 4, i % 3, 60 + i, 41 + i);
    check(enqReady == 1'b0, "R7 full enqReady", int'(enqReady), 0);
    enq(1, 1, 99, 63);
    bankBusy[3] = 1'b0;
    idle(30);
    check(logN - base == 8, "R7 grants from full queue", logN - base, 8);
    seen = 0;
    for (int k = base; k < logN; k++) if (logCol[k] == 6'd63) seen = 1;
    check(!seen, "R7 dropped request granted", int'(seen), 0);
    check(enqReady == 1'b1, "R7 ready after drain", int'(enqReady), 1);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    testReset();
    testLatency();
    testCap();
    testBusy();
    testHit();
    testOldest();
    testFull();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule